// File: doc/BRIEF.md
# Status Register Write Protection Unit

This unit keeps the eight-bit status register of a serial nonvolatile byte memory and makes every write-permission decision for that memory. A serial front end, outside this block, decodes each command and gives it as a one-cycle strobe. Those strobes are: set write enable, clear write enable, status write with its data byte, array write in progress, and end of transaction (chip select rising). The front end also supplies the active-low write-protect pin and the byte address it is about to store. The unit returns three things: the status byte for status reads, a per-byte grant for the memory array, and a grant for status writes.

Protection has three tiers. A write-enable latch must be set by an explicit command before any write. Two block-protect bits select a protected region of the array: none, the upper quarter, the upper half, or all of it. A protect-enable bit decides whether the external write-protect pin may lock the status register. The write-enable latch is used up by every write-class transaction and drops when that transaction ends. The nonvolatile bits are plain registers here, and reset loads them from parameters.

Top module: `wp_status_unit`

## Requirements
- R1: The status byte has protect-enable in bit 7, block-protect in bits 3:2 and write-enable in bit 1. Bits 6:4 and bit 0 always read 0. After reset, write-enable is 0 and protect-enable and block-protect take their parameter defaults (0 and 00 by default).
- R2: A set-write-enable strobe makes bit 1 read 1 from the next cycle on. A status write never changes bit 1, whatever value bit 1 of its data holds.
- R3: A clear-write-enable strobe makes bit 1 read 0 from the next cycle on.
- R4: When a transaction that contained a clear-write-enable, a status write or an array write ends, bit 1 reads 0 from the cycle after the end strobe. When a transaction without any of these ends, bit 1 keeps its value.
- R5: Block-protect 00 protects nothing, 01 protects 0x1800-0x1FFF, 10 protects 0x1000-0x1FFF and 11 protects 0x0000-0x1FFF (13-bit addresses by default, with the region scaling with the address width).
- R6: The array grant is 1 exactly when write-enable is 1 and the address lies outside the protected region. The write-protect pin has no effect on it.
- R7: The status grant is 1 exactly when write-enable is 1 and not both protect-enable is 1 and the write-protect pin is low. While protect-enable is 0, the pin is ignored.
- R8: A status write that is granted loads protect-enable from data bit 7 and block-protect from data bits 3:2, visible the next cycle. Data bits 6:4 and 0 are ignored.
- R9: A status write that is refused leaves protect-enable and block-protect unchanged, but write-enable is still cleared when its transaction ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wren | input | 1 | Set-write-enable command strobe |
| cmd_wrdi | input | 1 | Clear-write-enable command strobe |
| cmd_wrsr | input | 1 | Status write strobe, qualified by wrsr_data |
| wrsr_data | input | 8 | Data byte offered to the status register |
| cmd_write | input | 1 | Array write transaction marker |
| cs_rise | input | 1 | End of transaction (chip select rising) |
| wp_n | input | 1 | Active-low write-protect pin |
| wr_addr | input | ADDR_W | Byte address of the array write under test |
| status_byte | output | 8 | Status register value for reads |
| array_wr_ok | output | 1 | Array byte write permitted |
| status_wr_ok | output | 1 | Status register write permitted |

## Verification
The assertions assume that the front end raises at most one of the five command and end-of-transaction strobes in any cycle. That matches a serial link where one command is decoded per transaction and the end of a transaction is its own event. The bench builds every directed and random step with that rule: it picks a single strobe or none in each cycle. It moves the write-protect pin and the address freely, because the grants must follow them combinationally.

// File: rtl/wp_pkg.sv
// Package: shared field positions, protection encodings and the status-byte packer.
// Assumes an eight-bit status register with fixed-zero filler bits.
package wp_pkg;

    localparam int STAT_W      = 8;
    localparam int POS_WPEN    = 7;
    localparam int POS_BP_HI   = 3;
    localparam int POS_BP_LO   = 2;
    localparam int POS_WEL     = 1;

    typedef enum logic [1:0] {
        BP_NONE    = 2'b00,
        BP_QUARTER = 2'b01,
        BP_HALF    = 2'b10,
        BP_ALL     = 2'b11
    } bp_e;

    typedef struct packed {
        logic wpen;
        bp_e  bp;
    } prot_t;

    // Assemble the readable status byte; filler positions are forced to zero.
    function automatic logic [STAT_W-1:0] pack_status(input prot_t p, input logic wel);
        logic [STAT_W-1:0] s;
        s                    = '0;
        s[POS_WPEN]          = p.wpen;
        s[POS_BP_HI:POS_BP_LO] = p.bp;
        s[POS_WEL]           = wel;
        return s;
    endfunction

endpackage

// File: rtl/wp_wel_latch.sv
// Write-enable latch with per-transaction consumption.
// Assumes at most one of set / clr_now / arm / end_txn is high in a cycle;
// if end_txn coincides with another strobe, the end of transaction wins.
module wp_wel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,       // enable command
    input  logic clr_now,   // disable command, acts at once
    input  logic arm,       // transaction is write-class, clear at its end
    input  logic end_txn,   // chip select rising
    output logic wel
);

    logic armed;

    // Hold the latch and the pending-clear flag for the open transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel   <= 1'b0;
            armed <= 1'b0;
        end else if (end_txn) begin
            if (armed) begin
                wel <= 1'b0;
            end
            armed <= 1'b0;
        end else begin
            if (clr_now) begin
                wel <= 1'b0;
            end else if (set) begin
                wel <= 1'b1;
            end
            if (arm) begin
                armed <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/wp_prot_regs.sv
// Protect-enable and block-protect storage (nonvolatile bits modelled as flops).
// Assumes load is already qualified by the status-write grant.
module wp_prot_regs
    import wp_pkg::*;
#(
    parameter logic       RST_WPEN = 1'b0,
    parameter logic [1:0] RST_BP   = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [STAT_W-1:0] data,
    output prot_t             prot
);

    logic unused_filler;
    assign unused_filler = ^{data[6:4], data[POS_WEL], data[0]};

    // Load the writable protection fields from an accepted status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot.wpen <= RST_WPEN;
            prot.bp   <= bp_e'(RST_BP);
        end else if (load) begin
            prot.wpen <= data[POS_WPEN];
            prot.bp   <= bp_e'(data[POS_BP_HI:POS_BP_LO]);
        end
    end

endmodule

// File: rtl/wp_range_check.sv
// Decides whether an address falls in the region selected by block-protect.
// Assumes ADDR_W >= 2; regions are the top quarter, top half or whole space.
module wp_range_check
    import wp_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  bp_e               bp,
    output logic              hit
);

    localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(3) << (ADDR_W - 2);
    localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);

    // Compare against the lower bound of the selected upper region.
    always_comb begin
        unique case (bp)
            BP_NONE:    hit = 1'b0;
            BP_QUARTER: hit = (addr >= QTR_BASE);
            BP_HALF:    hit = (addr >= HALF_BASE);
            BP_ALL:     hit = 1'b1;
            default:    hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/wp_status_unit.sv
// Top: status register and write-permission decisions for a serial byte memory.
// Assumes the front end gives one strobe per cycle at most and holds wr_addr
// valid whenever it consults array_wr_ok. Grants are combinational.
module wp_status_unit
    import wp_pkg::*;
#(
    parameter int         ADDR_W   = 13,
    parameter logic       RST_WPEN = 1'b0,
    parameter logic [1:0] RST_BP   = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic [7:0]        wrsr_data,
    input  logic              cmd_write,
    input  logic              cs_rise,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        status_byte,
    output logic              array_wr_ok,
    output logic              status_wr_ok
);

    logic  wel;
    prot_t prot;
    logic  in_region;
    logic  pin_locks;

    wp_wel_latch u_wel (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (cmd_wren),
        .clr_now (cmd_wrdi),
        .arm     (cmd_wrdi | cmd_wrsr | cmd_write),
        .end_txn (cs_rise),
        .wel     (wel)
    );

    wp_prot_regs #(
        .RST_WPEN (RST_WPEN),
        .RST_BP   (RST_BP)
    ) u_prot (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cmd_wrsr & status_wr_ok),
        .data  (wrsr_data),
        .prot  (prot)
    );

    wp_range_check #(
        .ADDR_W (ADDR_W)
    ) u_range (
        .addr (wr_addr),
        .bp   (prot.bp),
        .hit  (in_region)
    );

    // Hardware pin locks the status register only when protect-enable is set.
    assign pin_locks    = prot.wpen & ~wp_n;
    // Status register grant: latch set and not pin-locked.
    assign status_wr_ok = wel & ~pin_locks;
    // Array grant: latch set and address outside the protected block.
    assign array_wr_ok  = wel & ~in_region;
    // Readable status byte.
    assign status_byte  = pack_status(prot, wel);

endmodule

// File: rtl/wp_status_unit_chk.sv
// Checker for wp_status_unit: port-level temporal properties, bound below.
// Tracks its own write-class flag per transaction to check end-of-transaction.
module wp_status_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wren,
    input logic       cmd_wrdi,
    input logic       cmd_wrsr,
    input logic       cmd_write,
    input logic       cs_rise,
    input logic       wp_n,
    input logic [7:0] status_byte,
    input logic       array_wr_ok,
    input logic       status_wr_ok
);

    logic wr_seen;

    // Remember whether the open transaction was write-class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen <= 1'b0;
        end else if (cs_rise) begin
            wr_seen <= 1'b0;
        end else if (cmd_wrdi | cmd_wrsr | cmd_write) begin
            wr_seen <= 1'b1;
        end
    end

    a_in_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_wren, cmd_wrdi, cmd_wrsr, cmd_write, cs_rise}));

    a_r2_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wren |=> status_byte[1]);

    a_r3_wrdi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wrdi |=> !status_byte[1]);

    a_r4_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && wr_seen) |=> !status_byte[1]);

    a_r4_end_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !wr_seen) |=> $stable(status_byte[1]));

    a_r5_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[3:2] == 2'b11) |-> !array_wr_ok);

    a_r6_array_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        array_wr_ok |-> status_byte[1]);

    a_r7_status_grant: assert property (@(posedge clk) disable iff (!rst_n)
        status_wr_ok |-> (status_byte[1] && !(status_byte[7] && !wp_n)));

    a_r9_refused_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr && !status_wr_ok) |=> ($stable(status_byte[7]) && $stable(status_byte[3:2])));

endmodule

bind wp_status_unit wp_status_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wren     (cmd_wren),
    .cmd_wrdi     (cmd_wrdi),
    .cmd_wrsr     (cmd_wrsr),
    .cmd_write    (cmd_write),
    .cs_rise      (cs_rise),
    .wp_n         (wp_n),
    .status_byte  (status_byte),
    .array_wr_ok  (array_wr_ok),
    .status_wr_ok (status_wr_ok)
);

// File: tb/wp_status_unit_test.sv
// Bench: behavioural reference model compared with the outputs every clock.
module wp_status_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_write = 0, cs_rise = 0;
    logic [7:0]    wrsr_data = '0;
    logic          wp_n = 1'b1;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    status_byte;
    logic          array_wr_ok, status_wr_ok;

    int vectors = 0;
    int errors  = 0;

    // Reference state
    int m_wel = 0, m_wpen = 0, m_bp = 0, m_armed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wp_status_unit #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
        .wrsr_data(wrsr_data), .cmd_write(cmd_write), .cs_rise(cs_rise),
        .wp_n(wp_n), .wr_addr(wr_addr),
        .status_byte(status_byte), .array_wr_ok(array_wr_ok), .status_wr_ok(status_wr_ok)
    );

    function automatic int in_region(int a, int bp);
        case (bp)
            0: return 0;
            1: return (a >= 'h1800) ? 1 : 0;
            2: return (a >= 'h1000) ? 1 : 0;
            default: return 1;
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, compare, then advance the model at posedge.
    task automatic step(string tag, int op, int d, int wpn, int addr);
        int exp_stat, exp_sw, exp_aw;
        cmd_wren  = (op == 1); cmd_wrdi = (op == 2); cmd_wrsr = (op == 3);
        cmd_write = (op == 4); cs_rise  = (op == 5);
        wrsr_data = 8'(d); wp_n = 1'(wpn); wr_addr = AW'(addr);
        #1;
        exp_stat = (m_wpen << 7) | (m_bp << 2) | (m_wel << 1);
        exp_sw   = (m_wel && !(m_wpen && !wpn)) ? 1 : 0;
        exp_aw   = (m_wel && !in_region(addr, m_bp)) ? 1 : 0;
        check(tag, "status_byte", int'(status_byte), exp_stat);
        check(tag, "status_wr_ok", int'(status_wr_ok), exp_sw);
        check(tag, "array_wr_ok", int'(array_wr_ok), exp_aw);
        @(posedge clk);
        case (op)
            1: m_wel = 1;
            2: begin m_wel = 0; m_armed = 1; end
            3: begin
                m_armed = 1;
                if (exp_sw != 0) begin m_wpen = (d >> 7) & 1; m_bp = (d >> 2) & 3; end
            end
            4: m_armed = 1;
            5: begin if (m_armed != 0) m_wel = 0; m_armed = 0; end
            default: ;
        endcase
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        step("R1", 0, 0, 1, 0);
        // R6: no grant without the latch, whatever the pin
        step("R6", 4, 0, 0, 'h0010);
        step("R4", 5, 0, 1, 0);
        // R2: enable, then a non-write end keeps it (R4)
        step("R2", 1, 0, 1, 0);
        step("R4", 5, 0, 1, 0);
        step("R2", 0, 0, 1, 0);
        // R8: granted status write of all ones, filler ignored
        step("R8", 3, 'hFF, 1, 0);
        step("R1", 0, 0, 1, 0);
        step("R4", 5, 0, 1, 0);
        // R5: whole array locked
        step("R2", 1, 0, 1, 0);
        step("R5", 4, 0, 1, 'h0000);
        step("R5", 0, 0, 0, 'h0FFF);
        step("R5", 0, 0, 1, 'h1FFF);
        step("R4", 5, 0, 1, 0);
        // R9: pin low with protect-enable refuses, latch still consumed
        step("R9", 1, 0, 0, 0);
        step("R7", 3, 'h04, 0, 0);
        step("R9", 0, 0, 0, 0);
        step("R9", 5, 0, 0, 0);
        step("R9", 0, 0, 0, 0);
        // R8: pin high allows; quarter region
        step("R7", 1, 0, 1, 0);
        step("R8", 3, 'h06, 1, 0);
        step("R2", 0, 0, 1, 0);
        step("R4", 5, 0, 1, 0);
        step("R6", 1, 0, 0, 0);
        step("R5", 4, 0, 0, 'h17FF);
        step("R5", 0, 0, 0, 'h1800);
        step("R5", 0, 0, 1, 'h1FFF);
        step("R6", 0, 0, 0, 'h0000);
        step("R4", 5, 0, 1, 0);
        step("R4", 0, 0, 1, 0);
        // R5: half region; R3: clear command
        step("R5", 1, 0, 1, 0);
        step("R8", 3, 'h08, 1, 0);
        step("R4", 5, 0, 1, 0);
        step("R5", 1, 0, 1, 0);
        step("R5", 0, 0, 1, 'h0FFF);
        step("R5", 0, 0, 1, 'h1000);
        step("R3", 2, 0, 1, 0);
        step("R3", 0, 0, 1, 'h0FFF);
        step("R4", 5, 0, 1, 0);
        // R7: protect-enable clear, pin ignored
        step("R7", 1, 0, 0, 0);
        step("R7", 0, 0, 0, 0);
        step("R2", 3, 'h00, 0, 0);
        step("R2", 0, 0, 0, 0);
        step("R4", 5, 0, 0, 0);
        // R2: status write with bit 1 set cannot raise the latch
        step("R2", 3, 'h02, 1, 0);
        step("R2", 0, 0, 1, 0);
        step("R4", 5, 0, 1, 0);
        // Random phase, one strobe at most per cycle
        for (int i = 0; i < 2000; i++) begin
            step("R6", int'($urandom_range(0, 5)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 1)), int'($urandom_range(0, 8191)));
        end
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule